// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer

This block is the byte-level protocol engine of a single-wire serial EEPROM slave. A bit-level transceiver in front of it recovers bus timing, decodes each byte the master sends and the acknowledge bit that follows that byte, and passes both on as one "slot". The sequencer answers each slot with a slave acknowledge decision: SAK or NoSAK. Behind the sequencer is a status/page controller. The sequencer sends it write-enable changes, status writes, whole-array fills, page bytes and page commits. It fetches read bytes from array storage one cycle ahead and puts them on a transmit stream.

The device has three modes: standby, active and idle. A standby pulse from the transceiver forces standby from any mode. The first header edge seen in standby moves the device to active. In active mode the sequencer checks the header, the device address, the opcode, the optional word address and the data phase. Each command has a fixed rule for where the master must end it. Any break of that rule ends the command with NoSAK and parks the device in idle. Only a standby pulse leaves idle.

There are three streams, and all use valid/ready. On the slot stream, `slot_ready` drops while a page byte is still waiting on the write stream; the transceiver must hold the slot until `slot_ready` returns. On the write stream, `wr_addr` and `wr_data` stay stable while `wr_valid` is high and `wr_ready` is low. On the transmit stream, `tx_data` stays put until it is taken.

Top module: `eeprom_cmd_seq`

## Requirements
- R1: After reset `dev_mode` is idle (2) and no response is given. A `sby_pulse` sets standby (0). In standby, `hdr_start` sets active (1).
- R2: The first slot of a command is the header byte. It always gets NoSAK. A MAK continues the command; a NoMAK sends the device to idle.
- R3: The device address slot must carry 0xA0, or it gets NoSAK and idle. A valid address followed by NoMAK gets SAK and returns to standby.
- R4: Opcodes are 0x03 read, 0x06 current-address read, 0x6C page write, 0x96 enable-writes, 0x91 disable-writes, 0x05 status read, 0x6E status write, 0x6D fill-zero, 0x67 fill-ones. Any other byte gets NoSAK and idle.
- R5: Enable-writes, disable-writes, fill-zero and fill-ones must be followed by NoMAK. That gives SAK, one pulse on `wel_set`, `wel_clr` or `fill_start` (with `fill_value` 0x00 or 0xFF), and standby. A MAK gives NoSAK, idle and no pulse.
- R6: While `busy` is high, read, current-address read, page write, status write and both fills get NoSAK and idle. Status read, enable-writes and disable-writes keep working.
- R7: A read takes an address high byte and then a low byte, each ended by MAK. The pointer loads at the low byte. Each data byte is fetched from `mem_rd_addr` and sent on `tx_data`. Every slot after a data byte gets SAK and advances the pointer, wrapping across the whole space. MAK fetches the next byte; NoMAK returns to standby.
- R8: A current-address read takes no address. It starts at the pointer left by the previous command.
- R9: Each page-write data slot is pushed as (`wr_addr`, `wr_data`) and gets SAK. The pointer then steps only in its low 4 bits, wrapping inside the 16-byte page. NoMAK on a data slot also pulses `page_commit` and returns to standby.
- R10: A NoMAK after the opcode of a read, current-address read, page write, status read or status write, or after either address byte, gives NoSAK and idle, with no commit.
- R11: A status read sends `status_in`, sampled at each send, once after the opcode and again after each MAK. NoMAK gives SAK and standby.
- R12: The status-write data byte followed by NoMAK gives SAK and pulses `sr_wr_en` with that byte. A MAK there gives NoSAK, idle and no pulse.
- R13: In standby and idle, slots are consumed without any response. In idle, `hdr_start` is also ignored.
- R14: While a pushed page byte is not yet accepted, `slot_ready` is low and the write stream holds its values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hdr_start | input | 1 | First header edge seen |
| sby_pulse | input | 1 | Standby pulse detected |
| slot_valid | input | 1 | Byte-plus-acknowledge slot available |
| slot_ready | output | 1 | Slot can be taken |
| slot_data | input | 8 | Byte sent by master (don't care after slave-sent bytes) |
| slot_mak | input | 1 | Master acknowledge: 1 MAK, 0 NoMAK |
| resp_valid | output | 1 | Acknowledge decision available |
| resp_sak | output | 1 | 1 SAK, 0 NoSAK |
| tx_valid | output | 1 | Byte ready to transmit |
| tx_ready | input | 1 | Transceiver takes the byte |
| tx_data | output | 8 | Byte to transmit |
| mem_rd_en | output | 1 | Array fetch request |
| mem_rd_addr | output | ADDR_W | Array fetch address |
| mem_rd_data | input | 8 | Fetched byte, one cycle after request |
| wr_valid | output | 1 | Page byte available |
| wr_ready | input | 1 | Page byte taken |
| wr_addr | output | ADDR_W | Page byte address |
| wr_data | output | 8 | Page byte value |
| page_commit | output | 1 | Start the page write cycle |
| wel_set | output | 1 | Enable writes |
| wel_clr | output | 1 | Disable writes |
| fill_start | output | 1 | Start whole-array fill |
| fill_value | output | 8 | Fill byte |
| sr_wr_en | output | 1 | Status write request |
| sr_wr_data | output | 8 | Status write byte |
| busy | input | 1 | Write cycle in progress |
| status_in | input | 8 | Live status byte |
| dev_mode | output | 2 | 0 standby, 1 active, 2 idle |

## Verification
The assertions assume the transceiver never offers a new slot while the transmit byte of the previous slot is still untaken. They also assume `busy` changes only between commands as the controller sees them. The bench keeps `tx_ready` high and lets each slot settle before sending the next, so both assumptions hold. Back-pressure is used only on the write stream. `busy` is changed only while the device sits in standby or idle.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;
  typedef enum logic [1:0] {MODE_STBY = 2'd0, MODE_ACTIVE = 2'd1, MODE_IDLE = 2'd2} mode_e;
  typedef enum logic [3:0] {
    OP_BAD, OP_READ, OP_CURRD, OP_WRITE, OP_WEN, OP_WDIS,
    OP_STRD, OP_STWR, OP_CLRALL, OP_FILLALL
  } op_e;
  typedef enum logic [3:0] {
    PH_HEADER, PH_DEVICE, PH_OPCODE, PH_ADDR_HI, PH_ADDR_LO,
    PH_READ, PH_WRITE, PH_STAT_RD, PH_STAT_WR
  } phase_e;
  localparam logic [7:0] CODE_READ    = 8'h03;
  localparam logic [7:0] CODE_CURRD   = 8'h06;
  localparam logic [7:0] CODE_WRITE   = 8'h6C;
  localparam logic [7:0] CODE_WEN     = 8'h96;
  localparam logic [7:0] CODE_WDIS    = 8'h91;
  localparam logic [7:0] CODE_STRD    = 8'h05;
  localparam logic [7:0] CODE_STWR    = 8'h6E;
  localparam logic [7:0] CODE_CLRALL  = 8'h6D;
  localparam logic [7:0] CODE_FILLALL = 8'h67;
endpackage

// File: rtl/eeprom_seq_decode.sv
module eeprom_seq_decode
  import eeprom_seq_pkg::*;
(
  input  logic [7:0] code,
  output op_e        op,
  output logic       no_tail,
  output logic       array_op
);
  always_comb begin
    case (code)
      CODE_READ:    op = OP_READ;
      CODE_CURRD:   op = OP_CURRD;
      CODE_WRITE:   op = OP_WRITE;
      CODE_WEN:     op = OP_WEN;
      CODE_WDIS:    op = OP_WDIS;
      CODE_STRD:    op = OP_STRD;
      CODE_STWR:    op = OP_STWR;
      CODE_CLRALL:  op = OP_CLRALL;
      CODE_FILLALL: op = OP_FILLALL;
      default:      op = OP_BAD;
    endcase
  end

  // opcodes that must be closed by NoMAK straight after the opcode byte
  assign no_tail  = (op == OP_WEN) || (op == OP_WDIS) || (op == OP_CLRALL) || (op == OP_FILLALL);
  // opcodes refused while a write cycle runs
  assign array_op = (op == OP_READ) || (op == OP_CURRD) || (op == OP_WRITE) ||
                    (op == OP_STWR) || (op == OP_CLRALL) || (op == OP_FILLALL);
endmodule

// File: rtl/eeprom_seq_ptr.sv
module eeprom_seq_ptr #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step_full,
  input  logic              step_page,
  output logic [ADDR_W-1:0] ptr,
  output logic [ADDR_W-1:0] ptr_plus
);
  localparam logic [ADDR_W-1:0] A_ONE = 1;
  localparam logic [PAGE_W-1:0] P_ONE = 1;

  assign ptr_plus = ptr + A_ONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (load_en) begin
      ptr <= load_val;
    end else if (step_full) begin
      ptr <= ptr_plus;
    end else if (step_page) begin
      ptr <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + P_ONE};
    end
  end

  AST_PAGE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (step_page && !load_en && !step_full) |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]))); // R9
endmodule

// File: rtl/eeprom_seq_txbuf.sv
module eeprom_seq_txbuf (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       fetch,
  input  logic [7:0] fetch_data,
  input  logic       stat_load,
  input  logic [7:0] stat_val,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic [7:0] tx_data
);
  logic fetch_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_q  <= 1'b0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (flush) begin
      fetch_q  <= 1'b0;
      tx_valid <= 1'b0;
    end else begin
      fetch_q <= fetch;
      if (fetch_q) begin
        tx_data  <= fetch_data;
        tx_valid <= 1'b1;
      end else if (stat_load) begin
        tx_data  <= stat_val;
        tx_valid <= 1'b1;
      end else if (tx_ready) begin
        tx_valid <= 1'b0;
      end
    end
  end

  AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !flush) |=> tx_valid); // R7
endmodule

// File: rtl/eeprom_cmd_seq.sv
module eeprom_cmd_seq
  import eeprom_seq_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          PAGE_W   = 4,
  parameter logic [7:0]  DEV_ADDR = 8'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_start,
  input  logic              sby_pulse,
  input  logic              slot_valid,
  output logic              slot_ready,
  input  logic [7:0]        slot_data,
  input  logic              slot_mak,
  output logic              resp_valid,
  output logic              resp_sak,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              page_commit,
  output logic              wel_set,
  output logic              wel_clr,
  output logic              fill_start,
  output logic [7:0]        fill_value,
  output logic              sr_wr_en,
  output logic [7:0]        sr_wr_data,
  input  logic              busy,
  input  logic [7:0]        status_in,
  output logic [1:0]        dev_mode
);
  mode_e  mode;
  phase_e phase, nx_phase;
  op_e    cur_op, dec_op;
  logic   dec_no_tail, dec_array;
  logic [7:0]        addr_hi;
  logic [ADDR_W-1:0] ptr, ptr_plus, ld_val, rd_addr_nx;
  logic slot_fire, stat_load;
  logic to_sby, to_idle, give_sak, keep_op, keep_hi, ld_ptr, stp_full, stp_page;
  logic rd_go, wr_go, commit_go, wen_go, wdis_go, fill_go, stwr_go, stld_go;

  assign slot_ready = !wr_valid;
  assign slot_fire  = slot_valid && slot_ready;
  assign dev_mode   = mode;
  assign ld_val     = ADDR_W'({addr_hi, slot_data});

  eeprom_seq_decode u_dec (.code(slot_data), .op(dec_op), .no_tail(dec_no_tail), .array_op(dec_array));

  eeprom_seq_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load_en(ld_ptr), .load_val(ld_val),
    .step_full(stp_full), .step_page(stp_page), .ptr(ptr), .ptr_plus(ptr_plus));

  eeprom_seq_txbuf u_tx (
    .clk(clk), .rst_n(rst_n), .flush(sby_pulse), .fetch(mem_rd_en), .fetch_data(mem_rd_data),
    .stat_load(stat_load), .stat_val(status_in), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data));

  // decision for the slot being taken in the current phase
  always_comb begin
    nx_phase = phase;  to_sby = 1'b0;  to_idle = 1'b0;  give_sak = 1'b0;
    keep_op = 1'b0;  keep_hi = 1'b0;  ld_ptr = 1'b0;  stp_full = 1'b0;  stp_page = 1'b0;
    rd_go = 1'b0;  rd_addr_nx = ptr;  wr_go = 1'b0;  commit_go = 1'b0;
    wen_go = 1'b0;  wdis_go = 1'b0;  fill_go = 1'b0;  stwr_go = 1'b0;  stld_go = 1'b0;
    if (mode == MODE_ACTIVE && slot_fire && !sby_pulse) begin
      case (phase)
        PH_HEADER: if (slot_mak) nx_phase = PH_DEVICE; else to_idle = 1'b1;
        PH_DEVICE: begin
          if (slot_data != DEV_ADDR) to_idle = 1'b1;
          else begin
            give_sak = 1'b1;
            if (slot_mak) nx_phase = PH_OPCODE; else to_sby = 1'b1;
          end
        end
        PH_OPCODE: begin
          if (dec_op == OP_BAD || (busy && dec_array)) to_idle = 1'b1;
          else if (dec_no_tail) begin
            if (slot_mak) to_idle = 1'b1;
            else begin
              give_sak = 1'b1;  to_sby = 1'b1;
              wen_go  = (dec_op == OP_WEN);
              wdis_go = (dec_op == OP_WDIS);
              fill_go = (dec_op == OP_CLRALL) || (dec_op == OP_FILLALL);
            end
          end else if (!slot_mak) to_idle = 1'b1;
          else begin
            give_sak = 1'b1;  keep_op = 1'b1;
            case (dec_op)
              OP_CURRD: begin nx_phase = PH_READ; rd_go = 1'b1; end
              OP_STRD:  begin nx_phase = PH_STAT_RD; stld_go = 1'b1; end
              OP_STWR:  nx_phase = PH_STAT_WR;
              default:  nx_phase = PH_ADDR_HI;
            endcase
          end
        end
        PH_ADDR_HI: if (slot_mak) begin give_sak = 1'b1; keep_hi = 1'b1; nx_phase = PH_ADDR_LO; end
                    else to_idle = 1'b1;
        PH_ADDR_LO: begin
          if (slot_mak) begin
            give_sak = 1'b1;  ld_ptr = 1'b1;
            if (cur_op == OP_READ) begin nx_phase = PH_READ; rd_go = 1'b1; rd_addr_nx = ld_val; end
            else nx_phase = PH_WRITE;
          end else to_idle = 1'b1;
        end
        PH_READ: begin
          give_sak = 1'b1;  stp_full = 1'b1;
          if (slot_mak) begin rd_go = 1'b1; rd_addr_nx = ptr_plus; end
          else to_sby = 1'b1;
        end
        PH_WRITE: begin
          give_sak = 1'b1;  wr_go = 1'b1;  stp_page = 1'b1;
          if (!slot_mak) begin commit_go = 1'b1; to_sby = 1'b1; end
        end
        PH_STAT_RD: begin
          give_sak = 1'b1;
          if (slot_mak) stld_go = 1'b1; else to_sby = 1'b1;
        end
        PH_STAT_WR: begin
          if (slot_mak) to_idle = 1'b1;
          else begin give_sak = 1'b1; stwr_go = 1'b1; to_sby = 1'b1; end
        end
        default: to_idle = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= MODE_IDLE;  phase <= PH_HEADER;  cur_op <= OP_BAD;  addr_hi <= '0;
      resp_valid <= 1'b0;  resp_sak <= 1'b0;  mem_rd_en <= 1'b0;  mem_rd_addr <= '0;
      wr_valid <= 1'b0;  wr_addr <= '0;  wr_data <= '0;  page_commit <= 1'b0;
      wel_set <= 1'b0;  wel_clr <= 1'b0;  fill_start <= 1'b0;  fill_value <= '0;
      sr_wr_en <= 1'b0;  sr_wr_data <= '0;  stat_load <= 1'b0;
    end else begin
      resp_valid <= 1'b0;  mem_rd_en <= 1'b0;  page_commit <= 1'b0;  wel_set <= 1'b0;
      wel_clr <= 1'b0;  fill_start <= 1'b0;  sr_wr_en <= 1'b0;  stat_load <= 1'b0;
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (sby_pulse) begin
        mode <= MODE_STBY;  phase <= PH_HEADER;
      end else if (mode == MODE_STBY && hdr_start) begin
        mode <= MODE_ACTIVE;  phase <= PH_HEADER;
      end else if (mode == MODE_ACTIVE && slot_fire) begin
        resp_valid <= 1'b1;  resp_sak <= give_sak;  phase <= nx_phase;
        if (to_idle) mode <= MODE_IDLE;
        else if (to_sby) mode <= MODE_STBY;
        if (keep_op) cur_op <= dec_op;
        if (keep_hi) addr_hi <= slot_data;
        mem_rd_en <= rd_go;
        if (rd_go) mem_rd_addr <= rd_addr_nx;
        if (wr_go) begin wr_valid <= 1'b1; wr_addr <= ptr; wr_data <= slot_data; end
        page_commit <= commit_go;
        wel_set <= wen_go;
        wel_clr <= wdis_go;
        fill_start <= fill_go;
        if (fill_go) fill_value <= (dec_op == OP_FILLALL) ? 8'hFF : 8'h00;
        sr_wr_en <= stwr_go;
        if (stwr_go) sr_wr_data <= slot_data;
        stat_load <= stld_go;
      end
    end
  end

  AST_HEADER_NOSAK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ACTIVE && phase == PH_HEADER && slot_fire && !sby_pulse) |=> (resp_valid && !resp_sak)); // R2
  AST_IDLE_NO_SAK: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && mode == MODE_IDLE) |-> !resp_sak); // R10
  AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_ACTIVE) |=> !resp_valid); // R13
  AST_IDLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_IDLE && !sby_pulse) |=> (mode == MODE_IDLE)); // R13
  AST_FILL_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    fill_start |-> !$past(busy)); // R6
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wel_set, wel_clr, fill_start, sr_wr_en, page_commit})); // R5
  AST_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R14
  AST_COMMIT_WITH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    page_commit |-> wr_valid); // R9
endmodule

// File: tb/test_eeprom_cmd_seq.sv
module test_eeprom_cmd_seq;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, hdr_start, sby_pulse, slot_valid, slot_ready, slot_mak;
  logic [7:0] slot_data;
  logic resp_valid, resp_sak, tx_valid, tx_ready, mem_rd_en;
  logic [7:0] tx_data, mem_rd_addr, mem_rd_data, wr_addr, wr_data, fill_value, sr_wr_data, status_in;
  logic wr_valid, wr_ready, page_commit, wel_set, wel_clr, fill_start, sr_wr_en, busy;
  logic [1:0] dev_mode;

  eeprom_cmd_seq i_eeprom_cmd_seq (
    .clk(clk), .rst_n(rst_n), .hdr_start(hdr_start), .sby_pulse(sby_pulse),
    .slot_valid(slot_valid), .slot_ready(slot_ready), .slot_data(slot_data), .slot_mak(slot_mak),
    .resp_valid(resp_valid), .resp_sak(resp_sak), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .page_commit(page_commit), .wel_set(wel_set), .wel_clr(wel_clr), .fill_start(fill_start),
    .fill_value(fill_value), .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data), .busy(busy),
    .status_in(status_in), .dev_mode(dev_mode));

  // array stand-in: registered read, content = address ^ 0x5A
  logic [7:0] rdq;
  always_ff @(posedge clk) rdq <= mem_rd_addr ^ 8'h5A;
  assign mem_rd_data = rdq;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit    exp_resp[$];  string resp_tag[$];
  logic [7:0]  exp_tx[$];   string tx_tag[$];
  logic [23:0] exp_op[$];   string op_tag[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cmp_op(input logic [23:0] got);
    if (exp_op.size() == 0) chk(1'b0, "R5", "unexpected action", int'(got), 0);
    else begin
      logic [23:0] e;
      string t;
      e = exp_op.pop_front();
      t = op_tag.pop_front();
      chk(got == e, t, "action", int'(got), int'(e));
    end
  endtask

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (resp_valid) begin
        if (exp_resp.size() == 0) chk(1'b0, "R13", "unexpected response", int'(resp_sak), 0);
        else begin
          bit e;
          string t;
          e = exp_resp.pop_front();
          t = resp_tag.pop_front();
          chk(resp_sak == e, t, "acknowledge", int'(resp_sak), int'(e));
        end
      end
      if (tx_valid && tx_ready) begin
        if (exp_tx.size() == 0) chk(1'b0, "R7", "unexpected tx byte", int'(tx_data), 0);
        else begin
          logic [7:0] e;
          string t;
          e = exp_tx.pop_front();
          t = tx_tag.pop_front();
          chk(tx_data == e, t, "tx byte", int'(tx_data), int'(e));
        end
      end
      if (wr_valid && wr_ready) cmp_op({8'h01, wr_addr, wr_data});
      if (page_commit) cmp_op({8'h02, 16'h0});
      if (wel_set)     cmp_op({8'h03, 16'h0});
      if (wel_clr)     cmp_op({8'h04, 16'h0});
      if (fill_start)  cmp_op({8'h05, 8'h0, fill_value});
      if (sr_wr_en)    cmp_op({8'h06, 8'h0, sr_wr_data});
    end
  end

  // ex: -1 no response expected, 0 NoSAK, 1 SAK
  task automatic send(input logic [7:0] b, input bit m, input int ex);
    if (ex >= 0) begin exp_resp.push_back(ex[0]); resp_tag.push_back(cur_req); end
    @(negedge clk);
    while (!slot_ready) @(negedge clk);
    slot_valid = 1'b1; slot_data = b; slot_mak = m;
    @(negedge clk);
    slot_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic push_tx(input logic [7:0] v);
    exp_tx.push_back(v); tx_tag.push_back(cur_req);
  endtask

  task automatic push_op(input logic [7:0] kind, input logic [7:0] a, input logic [7:0] d);
    exp_op.push_back({kind, a, d}); op_tag.push_back(cur_req);
  endtask

  task automatic header(input bit m);
    @(negedge clk) hdr_start = 1'b1;
    @(negedge clk) hdr_start = 1'b0;
    send(8'h55, m, 0);
  endtask

  task automatic open_cmd(input logic [7:0] code, input bit m, input int ex);
    header(1'b1);
    send(8'hA0, 1'b1, 1);
    send(code, m, ex);
  endtask

  task automatic stby();
    @(negedge clk) sby_pulse = 1'b1;
    @(negedge clk) sby_pulse = 1'b0;
  endtask

  task automatic check_mode(input logic [1:0] exp);
    repeat (3) @(negedge clk);
    chk(dev_mode == exp, cur_req, "dev_mode", int'(dev_mode), int'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hdr_start = 1'b0; sby_pulse = 1'b0; slot_valid = 1'b0; slot_mak = 1'b0;
    slot_data = '0; tx_ready = 1'b1; wr_ready = 1'b1; busy = 1'b0; status_in = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    chk(dev_mode == 2'd2, "R1", "reset mode", int'(dev_mode), 2);
    chk(!resp_valid, "R1", "reset response", int'(resp_valid), 0);

    cur_req = "R13";   // idle ignores header edge and slots
    @(negedge clk) hdr_start = 1'b1;
    @(negedge clk) hdr_start = 1'b0;
    send(8'h55, 1'b1, -1);
    check_mode(2'd2);

    cur_req = "R1";
    stby(); check_mode(2'd0);
    cur_req = "R13"; send(8'h55, 1'b1, -1); check_mode(2'd0);
    cur_req = "R1";
    @(negedge clk) hdr_start = 1'b1;
    @(negedge clk) hdr_start = 1'b0;
    check_mode(2'd1);
    cur_req = "R2"; send(8'h55, 1'b1, 0);
    cur_req = "R5"; send(8'hA0, 1'b1, 1);
    push_op(8'h03, 8'h00, 8'h00); send(8'h96, 1'b0, 1); check_mode(2'd0);

    cur_req = "R3"; header(1'b1); send(8'hA1, 1'b1, 0); check_mode(2'd2);
    stby(); header(1'b1); send(8'hA0, 1'b0, 1); check_mode(2'd0);
    cur_req = "R2"; header(1'b0); check_mode(2'd2);
    stby();
    cur_req = "R4"; open_cmd(8'h42, 1'b1, 0); check_mode(2'd2);
    stby();

    cur_req = "R9";    // page write wrapping inside page 0x30
    open_cmd(8'h6C, 1'b1, 1);
    send(8'h00, 1'b1, 1); send(8'h3E, 1'b1, 1);
    push_op(8'h01, 8'h3E, 8'h11); send(8'h11, 1'b1, 1);
    push_op(8'h01, 8'h3F, 8'h22); send(8'h22, 1'b1, 1);
    push_op(8'h01, 8'h30, 8'h33); push_op(8'h02, 8'h00, 8'h00); send(8'h33, 1'b0, 1);
    check_mode(2'd0);

    cur_req = "R7";    // sequential read wrapping the whole space
    open_cmd(8'h03, 1'b1, 1);
    send(8'h00, 1'b1, 1);
    push_tx(8'hFE ^ 8'h5A); send(8'hFE, 1'b1, 1);
    push_tx(8'hFF ^ 8'h5A); send(8'h00, 1'b1, 1);
    push_tx(8'h00 ^ 8'h5A); send(8'h00, 1'b1, 1);
    send(8'h00, 1'b0, 1);
    check_mode(2'd0);

    cur_req = "R8";
    push_tx(8'h01 ^ 8'h5A); open_cmd(8'h06, 1'b1, 1);
    send(8'h00, 1'b0, 1); check_mode(2'd0);

    cur_req = "R11";
    status_in = 8'h02; push_tx(8'h02); open_cmd(8'h05, 1'b1, 1);
    repeat (3) @(negedge clk);
    status_in = 8'h03; push_tx(8'h03); send(8'h00, 1'b1, 1);
    send(8'h00, 1'b0, 1); check_mode(2'd0);

    cur_req = "R12";
    open_cmd(8'h6E, 1'b1, 1); push_op(8'h06, 8'h00, 8'h0C); send(8'h0C, 1'b0, 1); check_mode(2'd0);
    open_cmd(8'h6E, 1'b1, 1); send(8'h0C, 1'b1, 0); check_mode(2'd2);
    stby();

    cur_req = "R5";
    push_op(8'h05, 8'h00, 8'h00); open_cmd(8'h6D, 1'b0, 1);
    open_cmd(8'h67, 1'b1, 0); check_mode(2'd2);
    stby();
    push_op(8'h05, 8'h00, 8'hFF); open_cmd(8'h67, 1'b0, 1);
    push_op(8'h04, 8'h00, 8'h00); open_cmd(8'h91, 1'b0, 1); check_mode(2'd0);

    cur_req = "R6";
    busy = 1'b1;
    open_cmd(8'h03, 1'b1, 0); check_mode(2'd2); stby();
    open_cmd(8'h6D, 1'b0, 0); check_mode(2'd2); stby();
    push_op(8'h03, 8'h00, 8'h00); open_cmd(8'h96, 1'b0, 1);
    status_in = 8'h01; push_tx(8'h01); open_cmd(8'h05, 1'b1, 1);
    send(8'h00, 1'b0, 1); check_mode(2'd0);
    busy = 1'b0;

    cur_req = "R10";
    open_cmd(8'h03, 1'b0, 0); check_mode(2'd2); stby();
    open_cmd(8'h6C, 1'b1, 1); send(8'h00, 1'b0, 0); check_mode(2'd2); stby();

    cur_req = "R14";
    wr_ready = 1'b0;
    open_cmd(8'h6C, 1'b1, 1); send(8'h00, 1'b1, 1); send(8'h10, 1'b1, 1);
    push_op(8'h01, 8'h10, 8'hAA); send(8'hAA, 1'b1, 1);
    repeat (2) @(negedge clk);
    chk(!slot_ready, "R14", "slot_ready while stalled", int'(slot_ready), 0);
    chk(wr_valid && wr_data == 8'hAA, "R14", "held write byte", int'(wr_data), 8'hAA);
    wr_ready = 1'b1;
    push_op(8'h01, 8'h11, 8'hBB); push_op(8'h02, 8'h00, 8'h00); send(8'hBB, 1'b0, 1);
    check_mode(2'd0);

    repeat (10) @(negedge clk);
    chk(exp_resp.size() == 0, "R2", "responses left", exp_resp.size(), 0);
    chk(exp_tx.size() == 0, "R7", "tx bytes left", exp_tx.size(), 0);
    chk(exp_op.size() == 0, "R9", "actions left", exp_op.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule